// File: doc/BRIEF.md
# Resumable SHA-256 Compression Engine

This block computes SHA-256 over a message that arrives as a stream of 32-bit words, one 64-byte block per operation, or a short final piece that the engine pads itself. Each operation begins with a `start` pulse. The chaining state for the operation comes from one of two places. With `newSession` high it is the eight standard initial hash words. With `newSession` low it is the 256-bit `resumeDigest` that software saved from an earlier operation. This lets a long message be hashed a block at a time, with other work run between the blocks.

When `padEnable` is high, the data is taken as the last piece of the message, `finalBytes` long. The engine adds the 0x80 marker, the zero fill and the 64-bit total bit length. Software supplies that length on `lenHi` and `lenLo`, because the engine keeps no count of its own. If the tail leaves no room for the length, the engine runs one extra block that holds the length.

When the operation ends, `resultAvail` rises and `digest` presents the eight state words. Both are held until software pulses `outAck`. A separate sticky flag records a bus error reported by the surrounding fabric. The flag stays set until software clears it.

Top module: `sha256_eng`

## Requirements
- R1: After reset, `resultAvail`, `dataReady` and `busErr` are all 0.
- R2: With `newSession`=1, the working state starts from the standard SHA-256 initial values, so the final piece "abc" (3 bytes, bit length 24) yields digest ba7816bf...f20015ad.
- R3: With `newSession`=0, the working state starts from `resumeDigest` (word A in bits 255:224), which is sampled on `start`.
- R4: With `padEnable`=0, the engine accepts exactly 16 words. It compresses them as one block with no padding, and the result is the chaining state plus the block result.
- R5: With `padEnable`=1 and `finalBytes` n ≤ 55, the engine accepts ceil(n/4) words. Message byte k sits in word k/4 at bits [31-8(k%4) -: 8]. Bytes at or beyond n are ignored. A single block is formed: 0x80 at byte n, zeros, then `lenHi` followed by `lenLo` in bytes 56..63. The case n=0 takes no words at all.
- R6: With `padEnable`=1 and 56 ≤ n ≤ 64, two blocks are compressed. The first holds the data (plus 0x80 at byte n when n<64). The second holds zeros, 0x80 in byte 0 only when n=64, and the length in bytes 56..63. Values of `finalBytes` above 64 act as 64.
- R7: `lenHi`/`lenLo` have no effect on the digest when `padEnable`=0.
- R8: `resultAvail` rises 66 cycles per compressed block after the clock edge that accepts the last word, or after the edge that accepts `start` when no words are expected.
- R9: `resultAvail` and `digest` hold their values until `outAck` is seen. The cycle after `outAck`, `resultAvail` is 0.
- R10: A `busErrIn` pulse sets `busErr` on the next cycle. It stays set until a cycle with `busErrClr` and no `busErrIn`. When both are asserted together, the set wins.
- R11: `start` is ignored unless the engine is idle. `dataReady` is high only while words of the current operation are still expected.
- R12: `digest` carries state word A in bits 255:224 through word H in bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (honoured when idle) |
| newSession | input | 1 | 1: standard initial values; 0: resume from `resumeDigest` |
| padEnable | input | 1 | Data is the final piece; engine appends padding and length |
| finalBytes | input | 7 | Byte count of the final piece (0..64) |
| resumeDigest | input | 256 | Saved chaining state, word A in the top bits |
| lenLo | input | 32 | Low word of total message length in bits |
| lenHi | input | 32 | High word of total message length in bits |
| dataValid | input | 1 | Message word present |
| dataWord | input | 32 | Message word, first byte in bits 31:24 |
| dataReady | output | 1 | Engine accepts a word this cycle |
| resultAvail | output | 1 | Digest ready, held until acknowledged |
| outAck | input | 1 | Release the output after readout |
| digest | output | 256 | Chaining state A..H |
| busErrIn | input | 1 | Bus error event from the fabric |
| busErrClr | input | 1 | Clear the bus-error flag |
| busErr | output | 1 | Sticky bus-error flag |

## Verification
The assertions check the handshake rules on every cycle. They cover the hold of `resultAvail` and `digest` until acknowledge, the release on the following cycle, the set, hold and clear of the bus-error flag, and the absence of `dataReady` while a result is pending. The scenarios cover everything that depends on the values being hashed: correct digests for new and resumed sessions, the byte masking and length placement for tails of 0, 3, 9, 20, 55, 56, 63 and 64 bytes, the length inputs having no effect on unpadded blocks, the exact 66-cycle-per-block latency, and a `start` pulse during a busy operation leaving the result unchanged.

// File: rtl/sha256_eng_pkg.sv
package sha256_eng_pkg;
  localparam int WORD_W      = 32;
  localparam int STATE_WORDS = 8;
  localparam int BLK_WORDS   = 16;
  localparam int NUM_ROUNDS  = 64;
  localparam int DIGEST_W    = WORD_W * STATE_WORDS;
  localparam int BLK_BYTES   = BLK_WORDS * 4;
  localparam int LEN_SLOT    = BLK_BYTES - 8;
  localparam int BYTE_CNT_W  = $clog2(BLK_BYTES + 1);
  localparam int WIDX_W      = $clog2(BLK_WORDS);
  localparam int WCNT_W      = WIDX_W + 1;
  localparam int RND_W       = $clog2(NUM_ROUNDS);

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t INIT_HASH [STATE_WORDS] = '{
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam word_t ROUND_K [NUM_ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  // How the block buffer is rewritten just before a compression starts
  typedef enum logic [1:0] {
    PAD_NONE,      // use buffer as received
    PAD_TAIL,      // mask after byte count, marker, no length
    PAD_TAIL_LEN,  // mask, marker and length in the last 8 bytes
    PAD_LEN_ONLY   // fresh block: optional marker and length only
  } pad_e;

  typedef enum logic [2:0] {S_IDLE, S_RECV, S_PREP, S_ROUND, S_ADD, S_DONE} state_e;

  typedef struct packed {
    logic                  loadIv;
    logic                  loadResume;
    logic                  wrWord;
    logic [WIDX_W-1:0]     wrIdx;
    logic                  initWork;
    pad_e                  padSel;
    logic [BYTE_CNT_W-1:0] padCnt;
    logic                  roundStep;
    logic [RND_W-1:0]      rnd;
    logic                  addBack;
  } strobe_t;

  function automatic word_t rotr(word_t x, int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction
endpackage

// File: rtl/sha256_eng_dp.sv
module sha256_eng_dp import sha256_eng_pkg::*; (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  word_t               dataWord,
  input  logic [DIGEST_W-1:0] resumeDigest,
  input  word_t               lenLo,
  input  word_t               lenHi,
  output logic [DIGEST_W-1:0] digest
);
  word_t hReg [STATE_WORDS];
  word_t wk [STATE_WORDS];
  word_t w [BLK_WORDS];
  word_t padded [BLK_WORDS];
  word_t lenLoQ, lenHiQ;
  word_t t1, t2, wNew;

  // Block image after padding, applied on initWork
  always_comb begin
    for (int j = 0; j < BLK_WORDS; j++) begin
      padded[j] = (stb.padSel == PAD_LEN_ONLY) ? '0 : w[j];
      if (stb.padSel == PAD_TAIL || stb.padSel == PAD_TAIL_LEN) begin
        for (int b = 0; b < 4; b++) begin
          if (4 * j + b == int'(stb.padCnt)) padded[j][WORD_W-1-8*b -: 8] = 8'h80;
          else if (4 * j + b > int'(stb.padCnt)) padded[j][WORD_W-1-8*b -: 8] = 8'h00;
        end
      end
    end
    if (stb.padSel == PAD_LEN_ONLY && int'(stb.padCnt) == BLK_BYTES)
      padded[0] = {8'h80, {(WORD_W-8){1'b0}}};
    if (stb.padSel == PAD_TAIL_LEN || stb.padSel == PAD_LEN_ONLY) begin
      padded[BLK_WORDS-2] = lenHiQ;
      padded[BLK_WORDS-1] = lenLoQ;
    end
  end

  // One round and one schedule step
  always_comb begin
    t1 = wk[7] + (rotr(wk[4], 6) ^ rotr(wk[4], 11) ^ rotr(wk[4], 25))
       + ((wk[4] & wk[5]) ^ (~wk[4] & wk[6])) + ROUND_K[stb.rnd] + w[0];
    t2 = (rotr(wk[0], 2) ^ rotr(wk[0], 13) ^ rotr(wk[0], 22))
       + ((wk[0] & wk[1]) ^ (wk[0] & wk[2]) ^ (wk[1] & wk[2]));
    wNew = (rotr(w[14], 17) ^ rotr(w[14], 19) ^ (w[14] >> 10)) + w[9]
         + (rotr(w[1], 7) ^ rotr(w[1], 18) ^ (w[1] >> 3)) + w[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STATE_WORDS; i++) begin
        hReg[i] <= '0;
        wk[i]   <= '0;
      end
      for (int i = 0; i < BLK_WORDS; i++) w[i] <= '0;
      lenLoQ <= '0;
      lenHiQ <= '0;
    end else begin
      if (stb.loadIv || stb.loadResume) begin
        lenLoQ <= lenLo;
        lenHiQ <= lenHi;
        for (int i = 0; i < STATE_WORDS; i++)
          hReg[i] <= stb.loadIv ? INIT_HASH[i] : resumeDigest[DIGEST_W-1-WORD_W*i -: WORD_W];
      end
      if (stb.wrWord) w[stb.wrIdx] <= dataWord;
      if (stb.initWork) begin
        for (int i = 0; i < STATE_WORDS; i++) wk[i] <= hReg[i];
        for (int i = 0; i < BLK_WORDS; i++) w[i] <= padded[i];
      end
      if (stb.roundStep) begin
        wk[0] <= t1 + t2;
        wk[4] <= wk[3] + t1;
        for (int i = 1; i < STATE_WORDS; i++) if (i != 4) wk[i] <= wk[i-1];
        for (int i = 0; i < BLK_WORDS - 1; i++) w[i] <= w[i+1];
        w[BLK_WORDS-1] <= wNew;
      end
      if (stb.addBack)
        for (int i = 0; i < STATE_WORDS; i++) hReg[i] <= hReg[i] + wk[i];
    end
  end

  for (genvar i = 0; i < STATE_WORDS; i++) begin : g_out
    assign digest[DIGEST_W-1-WORD_W*i -: WORD_W] = hReg[i];
  end
endmodule

// File: rtl/sha256_eng_ctrl.sv
module sha256_eng_ctrl import sha256_eng_pkg::*; (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  newSession,
  input  logic                  padEnable,
  input  logic [BYTE_CNT_W-1:0] finalBytes,
  input  logic                  dataValid,
  output logic                  dataReady,
  output logic                  resultAvail,
  input  logic                  outAck,
  input  logic                  busErrIn,
  input  logic                  busErrClr,
  output logic                  busErr,
  output strobe_t               stb
);
  state_e                st;
  logic                  padQ, secondQ, busErrQ;
  logic [BYTE_CNT_W-1:0] cntQ, cntIn;
  logic [WCNT_W-1:0]     nWordsQ, nWordsIn;
  logic [WIDX_W-1:0]     wIdx;
  logic [RND_W-1:0]      rndQ;
  logic                  needSecond;

  assign cntIn      = (finalBytes > BYTE_CNT_W'(BLK_BYTES)) ? BYTE_CNT_W'(BLK_BYTES) : finalBytes;
  assign nWordsIn   = padEnable ? WCNT_W'((int'(cntIn) + 3) / 4) : WCNT_W'(BLK_WORDS);
  assign needSecond = padQ && !secondQ && (int'(cntQ) >= LEN_SLOT);

  assign dataReady   = (st == S_RECV);
  assign resultAvail = (st == S_DONE);
  assign busErr      = busErrQ;

  always_comb begin
    stb        = '0;
    stb.padCnt = cntQ;
    stb.rnd    = rndQ;
    stb.wrIdx  = wIdx;
    case (st)
      S_IDLE: begin
        stb.loadIv     = start && newSession;
        stb.loadResume = start && !newSession;
      end
      S_RECV:  stb.wrWord = dataValid;
      S_PREP: begin
        stb.initWork = 1'b1;
        if (!padQ)                           stb.padSel = PAD_NONE;
        else if (secondQ)                    stb.padSel = PAD_LEN_ONLY;
        else if (int'(cntQ) < LEN_SLOT)      stb.padSel = PAD_TAIL_LEN;
        else if (int'(cntQ) < BLK_BYTES)     stb.padSel = PAD_TAIL;
        else                                 stb.padSel = PAD_NONE;
      end
      S_ROUND: stb.roundStep = 1'b1;
      S_ADD:   stb.addBack   = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE;
      padQ <= 1'b0;
      secondQ <= 1'b0;
      cntQ <= '0;
      nWordsQ <= '0;
      wIdx <= '0;
      rndQ <= '0;
      busErrQ <= 1'b0;
    end else begin
      if (busErrIn)       busErrQ <= 1'b1;
      else if (busErrClr) busErrQ <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          padQ    <= padEnable;
          cntQ    <= cntIn;
          nWordsQ <= nWordsIn;
          secondQ <= 1'b0;
          wIdx    <= '0;
          st      <= (nWordsIn == '0) ? S_PREP : S_RECV;
        end
        S_RECV: if (dataValid) begin
          wIdx <= wIdx + 1'b1;
          if ({1'b0, wIdx} == nWordsQ - 1'b1) st <= S_PREP;
        end
        S_PREP: begin
          rndQ <= '0;
          st   <= S_ROUND;
        end
        S_ROUND: begin
          rndQ <= rndQ + 1'b1;
          if (rndQ == RND_W'(NUM_ROUNDS - 1)) st <= S_ADD;
        end
        S_ADD: begin
          secondQ <= needSecond;
          st      <= needSecond ? S_PREP : S_DONE;
        end
        S_DONE: if (outAck) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sha256_eng.sv
module sha256_eng import sha256_eng_pkg::*; (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  newSession,
  input  logic                  padEnable,
  input  logic [BYTE_CNT_W-1:0] finalBytes,
  input  logic [DIGEST_W-1:0]   resumeDigest,
  input  logic [WORD_W-1:0]     lenLo,
  input  logic [WORD_W-1:0]     lenHi,
  input  logic                  dataValid,
  input  logic [WORD_W-1:0]     dataWord,
  output logic                  dataReady,
  output logic                  resultAvail,
  input  logic                  outAck,
  output logic [DIGEST_W-1:0]   digest,
  input  logic                  busErrIn,
  input  logic                  busErrClr,
  output logic                  busErr
);
  strobe_t stb;

  sha256_eng_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .newSession(newSession),
    .padEnable(padEnable), .finalBytes(finalBytes), .dataValid(dataValid),
    .dataReady(dataReady), .resultAvail(resultAvail), .outAck(outAck),
    .busErrIn(busErrIn), .busErrClr(busErrClr), .busErr(busErr), .stb(stb));

  sha256_eng_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dataWord(dataWord),
    .resumeDigest(resumeDigest), .lenLo(lenLo), .lenHi(lenHi), .digest(digest));
endmodule

// File: rtl/sha256_eng_chk.sv
module sha256_eng_chk (
  input logic         clk,
  input logic         rstN,
  input logic         resultAvail,
  input logic         outAck,
  input logic         dataReady,
  input logic [255:0] digest,
  input logic         busErrIn,
  input logic         busErrClr,
  input logic         busErr
);
  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rstN)
    resultAvail && !outAck |=> resultAvail);
  a_r9_digest_stable: assert property (@(posedge clk) disable iff (!rstN)
    resultAvail && !outAck |=> $stable(digest));
  a_r9_release: assert property (@(posedge clk) disable iff (!rstN)
    resultAvail && outAck |=> !resultAvail);
  a_r11_no_ready_pending: assert property (@(posedge clk) disable iff (!rstN)
    resultAvail |-> !dataReady);
  a_r10_set: assert property (@(posedge clk) disable iff (!rstN)
    busErrIn |=> busErr);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    busErr && !busErrClr |=> busErr);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    busErrClr && !busErrIn |=> !busErr);
endmodule

bind sha256_eng sha256_eng_chk u_chk (
  .clk(clk), .rstN(rstN), .resultAvail(resultAvail), .outAck(outAck),
  .dataReady(dataReady), .digest(digest), .busErrIn(busErrIn),
  .busErrClr(busErrClr), .busErr(busErr));

// File: tb/sha256_eng_bench.sv
`timescale 1ns/1ps
module sha256_eng_bench;
  typedef logic [7:0] byte_q_t[$];
  typedef struct { logic [255:0] dig; int blocks; string req; } exp_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 0, newSession = 0, padEnable = 0, dataValid = 0, outAck = 0;
  logic busErrIn = 0, busErrClr = 0;
  logic [6:0] finalBytes = '0;
  logic [255:0] resumeDigest = '0;
  logic [31:0] lenLo = '0, lenHi = '0, dataWord = '0;
  logic dataReady, resultAvail, busErr;
  logic [255:0] digest;

  int nChecks = 0, nFails = 0, cyc = 0, lastAcc = 0, doneCnt = 0;
  exp_t sb[$];
  logic [255:0] obsDigest;
  logic [31:0] kTab[64];
  logic [255:0] ivVec;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sha256_eng u_sha256_eng (
    .clk(clk), .rstN(rstN), .start(start), .newSession(newSession),
    .padEnable(padEnable), .finalBytes(finalBytes), .resumeDigest(resumeDigest),
    .lenLo(lenLo), .lenHi(lenHi), .dataValid(dataValid), .dataWord(dataWord),
    .dataReady(dataReady), .resultAvail(resultAvail), .outAck(outAck),
    .digest(digest), .busErrIn(busErrIn), .busErrClr(busErrClr), .busErr(busErr));

  task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference constants from fractional parts of roots of primes
  function automatic logic [31:0] frac32(real x);
    real f = (x - $floor(x)) * 4294967296.0;
    longint v = longint'($floor(f));
    return v[31:0];
  endfunction

  task automatic build_consts();
    int n = 2, found = 0;
    while (found < 64) begin
      bit prime = 1;
      for (int d = 2; d * d <= n; d++) if (n % d == 0) prime = 0;
      if (prime) begin
        kTab[found] = frac32($pow(real'(n), 1.0 / 3.0));
        if (found < 8) ivVec[255-32*found -: 32] = frac32($sqrt(real'(n)));
        found++;
      end
      n++;
    end
  endtask

  function automatic logic [31:0] rr(logic [31:0] x, int s);
    return (x >> s) | (x << (32 - s));
  endfunction

  function automatic logic [255:0] ref_block(logic [255:0] hin, logic [511:0] blk);
    logic [31:0] w[64];
    logic [31:0] v[8];
    logic [31:0] t1, t2;
    logic [255:0] res;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
    for (int i = 0; i < 8; i++) v[i] = hin[255-32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kTab[t] + w[t];
      t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      for (int i = 7; i > 0; i--) v[i] = v[i-1];
      v[4] = v[4] + t1;
      v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) res[255-32*i -: 32] = v[i] + hin[255-32*i -: 32];
    return res;
  endfunction

  function automatic logic [255:0] ref_op(logic [255:0] hin, byte_q_t msg, bit pad,
                                          int cnt, logic [63:0] bits);
    byte_q_t b;
    logic [255:0] h = hin;
    logic [511:0] blk;
    int used = pad ? cnt : 64;
    for (int i = 0; i < used; i++) b.push_back(msg[i]);
    if (pad) begin
      b.push_back(8'h80);
      while (b.size() % 64 != 56) b.push_back(8'h00);
      for (int k = 7; k >= 0; k--) b.push_back(bits[8*k +: 8]);
    end
    for (int blkN = 0; blkN < b.size() / 64; blkN++) begin
      for (int j = 0; j < 64; j++) blk[511-8*j -: 8] = b[64*blkN + j];
      h = ref_block(h, blk);
    end
    return h;
  endfunction

  function automatic byte_q_t mk_msg(int len, int seed);
    byte_q_t m;
    for (int i = 0; i < len; i++) m.push_back(8'((i * 37 + seed * 11 + 5) & 255));
    return m;
  endfunction

  // Driver: predicts, pushes to scoreboard, drives start and words
  task automatic run_op(string req, bit ns, bit pad, int cnt, logic [255:0] res,
                        logic [63:0] bits, byte_q_t msg);
    exp_t e;
    int nW = pad ? (cnt + 3) / 4 : 16;
    int len = pad ? cnt : 64;
    int target = doneCnt + 1;
    e.dig = ref_op(ns ? ivVec : res, msg, pad, cnt, bits);
    e.blocks = (pad && cnt >= 56) ? 2 : 1;
    e.req = req;
    sb.push_back(e);
    @(negedge clk);
    start = 1; newSession = ns; padEnable = pad; finalBytes = 7'(cnt);
    resumeDigest = res; lenLo = bits[31:0]; lenHi = bits[63:32];
    lastAcc = cyc + 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < nW; ) begin
      dataValid = ((i + cyc) % 3) != 0;
      for (int b = 0; b < 4; b++)
        dataWord[31-8*b -: 8] = (4 * i + b < len) ? msg[4*i + b] : 8'hA5;
      if (dataValid && dataReady) begin
        lastAcc = cyc + 1;
        i++;
      end
      @(negedge clk);
    end
    dataValid = 0;
    // R11: no more words wanted; a start while busy must change nothing
    check(dataReady == 1'b0, "R11 ready after last word", 256'(dataReady), 256'(0));
    start = 1; newSession = ~ns; padEnable = ~pad; resumeDigest = ~res;
    @(negedge clk);
    start = 0;
    wait (doneCnt == target);
  endtask

  // Monitor: compares results as they appear
  initial begin
    exp_t e;
    logic [255:0] held;
    forever begin
      @(negedge clk);
      if (resultAvail) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected result", digest, '0);
        end else begin
          e = sb.pop_front();
          check(digest == e.dig, e.req, digest, e.dig);
          check(cyc == lastAcc + 66 * e.blocks, "R8 latency", 256'(cyc),
                256'(lastAcc + 66 * e.blocks));
        end
        held = digest;
        obsDigest = digest;
        @(negedge clk);
        @(negedge clk);
        check(resultAvail && digest == held, "R9 hold", digest, held);
        outAck = 1;
        @(negedge clk);
        outAck = 0;
        check(resultAvail == 1'b0, "R9 release", 256'(resultAvail), 256'(0));
        doneCnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [255:0] d1, r1;
    byte_q_t abc;
    build_consts();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(resultAvail == 0, "R1 resultAvail", 256'(resultAvail), 0);
    check(dataReady == 0, "R1 dataReady", 256'(dataReady), 0);
    check(busErr == 0, "R1 busErr", 256'(busErr), 0);
    rstN = 1;
    @(negedge clk);

    abc.push_back(8'h61); abc.push_back(8'h62); abc.push_back(8'h63);
    check(ref_op(ivVec, abc, 1, 3, 64'd24) ==
          256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad,
          "R2 model known answer", ref_op(ivVec, abc, 1, 3, 64'd24), '0);
    run_op("R2 new session abc", 1, 1, 3, '0, 64'd24, abc);
    check(obsDigest[255:224] == 32'hba7816bf, "R12 word A on top",
          256'(obsDigest[255:224]), 256'(32'hba7816bf));

    run_op("R5 empty tail", 1, 1, 0, '0, 64'd0, mk_msg(0, 0));
    check(obsDigest == 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855,
          "R5 empty known answer", obsDigest, '0);

    run_op("R4 full block", 1, 0, 0, '0, 64'hDEAD_BEEF_1234_5678, mk_msg(64, 1));
    d1 = obsDigest;
    run_op("R3 resume tail 20", 0, 1, 20, d1, 64'd672, mk_msg(20, 2));
    run_op("R7 length ignored", 1, 0, 0, '0, 64'h0, mk_msg(64, 1));
    check(obsDigest == d1, "R7 same digest", obsDigest, d1);

    run_op("R5 tail 55", 1, 1, 55, '0, 64'd440, mk_msg(55, 3));
    run_op("R6 tail 56", 1, 1, 56, '0, 64'd448, mk_msg(56, 4));
    r1 = 256'h0123456789abcdef_fedcba9876543210_55aa55aa33cc33cc_0f0f0f0ff0f0f0f0;
    run_op("R6 resume tail 63", 0, 1, 63, r1, 64'h1_0000_0DF8, mk_msg(63, 5));
    run_op("R6 tail 64", 1, 1, 64, '0, 64'd512, mk_msg(64, 6));
    run_op("R3 resume tail 9", 0, 1, 9, ~r1, 64'd1096, mk_msg(9, 7));

    // R10 sticky bus error
    @(negedge clk); busErrIn = 1;
    @(negedge clk); busErrIn = 0;
    check(busErr == 1, "R10 set", 256'(busErr), 1);
    repeat (3) @(negedge clk);
    check(busErr == 1, "R10 held", 256'(busErr), 1);
    busErrIn = 1; busErrClr = 1;
    @(negedge clk); busErrIn = 0;
    check(busErr == 1, "R10 set wins", 256'(busErr), 1);
    @(negedge clk); busErrClr = 0;
    check(busErr == 0, "R10 cleared", 256'(busErr), 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule